// File: doc/BRIEF.md
# Ring Bracket Access Checker

This block judges a single operand access against the protection attributes of the segment being touched. It is given the three ring brackets of the segment, its read-permit, execute and gate flags, its entry bound and its length bound. It also receives the ring the access is made from (the effective ring), the ring and segment number of the running procedure, the target segment number, the 18-bit computed address, the ring-alarm value, an absolute-mode flag, and a 2-bit access class. From these it builds a 16-bit violation mask, a fault flag and an adjusted effective ring.

Three rule sets run side by side, one for each class: plain read, transfer and call. A common set covers bracket ordering and the segment length for every class. Every violated rule sets its own bit, so a single result reports all the failures together rather than only the first. The result is captured on a valid strobe and held until the next strobe.

A two-state controller gates the outputs. In ST_EMPTY, which reset enters, no result has been taken and every output reads zero. The load transition from ST_EMPTY to ST_HOLD happens on a valid strobe. In ST_HOLD the captured result drives the outputs, and the reload transition (ST_HOLD to ST_HOLD on a valid strobe) replaces it. The reset transition returns either state to ST_EMPTY.

Top module: `ring_access_checker`

## Requirements
- R1: Mask bit 0 is set whenever the brackets fail low ≤ mid ≤ high (unsigned), for every access class.
- R2: For a plain read, bit 3 is set when the effective ring exceeds the mid bracket. With read-permit clear, the adjusted ring becomes the procedure ring, and bit 4 is set if the procedure and target segment numbers differ. With read-permit set, the adjusted ring equals the effective ring.
- R3: For a call, bit 2 is set when the execute flag is clear. Bit 7 is set when the computed address is greater than or equal to the entry bound. The bit 7 test is skipped when the gate flag is set, or when both segment numbers match and absolute mode is off.
- R4: For a call, bit 8 is set when the effective ring exceeds the high bracket, and bit 9 when it is below the low bracket. Bit 10 is set when the effective ring exceeds the procedure ring while the procedure ring is below the mid bracket. The adjusted ring is the effective ring clamped to at most the mid bracket.
- R5: For a transfer, bit 1 is set when the effective ring lies outside [low, mid], bit 2 when the execute flag is clear, and bit 12 when the procedure ring differs from the effective ring. The adjusted ring equals the effective ring.
- R6: For a transfer with a nonzero ring-alarm value, bit 13 is set unless the procedure ring is strictly below that value. A zero alarm value disables the test.
- R7: For every class, bit 15 is set when computed-address bits [17:4] exceed the length bound. Equality does not set it.
- R8: The fault output is 1 exactly when the visible mask is nonzero.
- R9: Mask, fault and adjusted ring are taken on the clock edge where chk_valid is 1 and stay unchanged while it is 0. After reset, until the first strobe, all three read zero.
- R10: Class code 0 is plain read, 1 is transfer, 2 is call, and 3 behaves as plain read. A rule of one class has no effect on another class: read-permit and segment mismatch do not affect a transfer, and the ring alarm does not affect a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_valid | input | 1 | Capture strobe for the current inputs |
| acc_class | input | 2 | Access class code |
| br_low | input | 3 | Low ring bracket |
| br_mid | input | 3 | Mid ring bracket |
| br_high | input | 3 | High ring bracket |
| rd_permit | input | 1 | Segment read-permit flag |
| exec_ok | input | 1 | Segment execute flag |
| gate_seg | input | 1 | Segment gate flag |
| entry_bound | input | 14 | First address outside the call entry area |
| len_bound | input | 14 | Highest allowed 16-word block index |
| eff_ring | input | 3 | Effective ring of the access |
| proc_ring | input | 3 | Ring of the running procedure |
| proc_seg | input | 15 | Segment number of the running procedure |
| tgt_seg | input | 15 | Segment number being accessed |
| comp_addr | input | 18 | Computed word address within the segment |
| alarm_ring | input | 3 | Ring-alarm value, zero disables |
| abs_mode | input | 1 | Absolute-mode flag |
| viol_mask | output | 16 | Captured violation bits |
| fault | output | 1 | Any violation present |
| ring_out | output | 3 | Adjusted effective ring |

## Verification
The hardest case to reach from the ports is the call entry-bound test. Whether bit 7 can fire depends at once on the gate flag, on whether the two segment numbers match, and on absolute mode, and it also needs an address at or past the bound. The vector table keeps the address pinned exactly at the bound and steps through each skip condition in turn: segments differ, gate set, segments equal with absolute mode off, and segments equal with absolute mode on. One more call vector breaks the execute, high-bracket and procedure-ring rules together, so the bench can see several bits accumulate alongside the clamp on the adjusted ring.

// File: rtl/ring_chk_pkg.sv
package ring_chk_pkg;

    localparam int MASK_W = 16;

    // violation bit positions (software decodes these)
    localparam int V_ORDER   = 0;
    localparam int V_XBRACK  = 1;
    localparam int V_NOEXEC  = 2;
    localparam int V_RDRING  = 3;
    localparam int V_RDSEG   = 4;
    localparam int V_ENTRY   = 7;
    localparam int V_CALLHI  = 8;
    localparam int V_CALLLO  = 9;
    localparam int V_CALLUP  = 10;
    localparam int V_XRING   = 12;
    localparam int V_ALARM   = 13;
    localparam int V_LENGTH  = 15;

    typedef enum logic [1:0] {
        ACC_READ     = 2'd0,
        ACC_XFER     = 2'd1,
        ACC_CALL     = 2'd2,
        ACC_READ_ALT = 2'd3
    } acc_class_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/rc_common_rules.sv
module rc_common_rules
    import ring_chk_pkg::*;
#(
    parameter int RING_W = 3,
    parameter int BND_W  = 14
) (
    input  logic [RING_W-1:0] br_low,
    input  logic [RING_W-1:0] br_mid,
    input  logic [RING_W-1:0] br_high,
    input  logic [BND_W-1:0]  addr_blk,
    input  logic [BND_W-1:0]  len_bound,
    output logic [MASK_W-1:0] mask
);
    always_comb begin
        mask = '0;
        if (!((br_low <= br_mid) && (br_mid <= br_high)))
            mask[V_ORDER] = 1'b1;
        if (addr_blk > len_bound)
            mask[V_LENGTH] = 1'b1;
    end
endmodule

// File: rtl/rc_read_rules.sv
module rc_read_rules
    import ring_chk_pkg::*;
#(
    parameter int RING_W = 3,
    parameter int SEG_W  = 15
) (
    input  logic [RING_W-1:0] br_mid,
    input  logic              rd_permit,
    input  logic [RING_W-1:0] eff_ring,
    input  logic [RING_W-1:0] proc_ring,
    input  logic [SEG_W-1:0]  proc_seg,
    input  logic [SEG_W-1:0]  tgt_seg,
    output logic [MASK_W-1:0] mask,
    output logic [RING_W-1:0] ring_adj
);
    always_comb begin
        mask     = '0;
        ring_adj = eff_ring;
        if (eff_ring > br_mid)
            mask[V_RDRING] = 1'b1;
        if (!rd_permit) begin
            ring_adj = proc_ring;
            if (proc_seg != tgt_seg)
                mask[V_RDSEG] = 1'b1;
        end
    end
endmodule

// File: rtl/rc_xfer_rules.sv
module rc_xfer_rules
    import ring_chk_pkg::*;
#(
    parameter int RING_W = 3
) (
    input  logic [RING_W-1:0] br_low,
    input  logic [RING_W-1:0] br_mid,
    input  logic              exec_ok,
    input  logic [RING_W-1:0] eff_ring,
    input  logic [RING_W-1:0] proc_ring,
    input  logic [RING_W-1:0] alarm_ring,
    output logic [MASK_W-1:0] mask,
    output logic [RING_W-1:0] ring_adj
);
    always_comb begin
        mask     = '0;
        ring_adj = eff_ring;
        if ((eff_ring < br_low) || (eff_ring > br_mid))
            mask[V_XBRACK] = 1'b1;
        if (!exec_ok)
            mask[V_NOEXEC] = 1'b1;
        if (proc_ring != eff_ring)
            mask[V_XRING] = 1'b1;
        if ((alarm_ring != '0) && !(proc_ring < alarm_ring))
            mask[V_ALARM] = 1'b1;
    end
endmodule

// File: rtl/rc_call_rules.sv
module rc_call_rules
    import ring_chk_pkg::*;
#(
    parameter int RING_W = 3,
    parameter int SEG_W  = 15,
    parameter int ADDR_W = 18,
    parameter int EB_W   = 14
) (
    input  logic [RING_W-1:0] br_low,
    input  logic [RING_W-1:0] br_mid,
    input  logic [RING_W-1:0] br_high,
    input  logic              exec_ok,
    input  logic              gate_seg,
    input  logic [EB_W-1:0]   entry_bound,
    input  logic [RING_W-1:0] eff_ring,
    input  logic [RING_W-1:0] proc_ring,
    input  logic [SEG_W-1:0]  proc_seg,
    input  logic [SEG_W-1:0]  tgt_seg,
    input  logic [ADDR_W-1:0] comp_addr,
    input  logic              abs_mode,
    output logic [MASK_W-1:0] mask,
    output logic [RING_W-1:0] ring_adj
);
    logic [ADDR_W-1:0] eb_ext;
    logic              skip_entry;

    assign eb_ext     = ADDR_W'(entry_bound);
    assign skip_entry = gate_seg || ((proc_seg == tgt_seg) && !abs_mode);

    always_comb begin
        mask     = '0;
        ring_adj = eff_ring;
        if (!exec_ok)
            mask[V_NOEXEC] = 1'b1;
        if (!skip_entry && (comp_addr >= eb_ext))
            mask[V_ENTRY] = 1'b1;
        if (eff_ring > br_high)
            mask[V_CALLHI] = 1'b1;
        if (eff_ring < br_low)
            mask[V_CALLLO] = 1'b1;
        if ((eff_ring > proc_ring) && (proc_ring < br_mid))
            mask[V_CALLUP] = 1'b1;
        if (eff_ring > br_mid)
            ring_adj = br_mid;
    end
endmodule

// File: rtl/ring_access_checker.sv
module ring_access_checker
    import ring_chk_pkg::*;
#(
    parameter int  RING_W    = 3,
    parameter int  SEG_W     = 15,
    parameter int  ADDR_W    = 18,
    parameter int  EB_W      = 14,
    parameter int  LEN_SHIFT = 4,
    localparam int BND_W     = ADDR_W - LEN_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic [1:0]        acc_class,
    input  logic [RING_W-1:0] br_low,
    input  logic [RING_W-1:0] br_mid,
    input  logic [RING_W-1:0] br_high,
    input  logic              rd_permit,
    input  logic              exec_ok,
    input  logic              gate_seg,
    input  logic [EB_W-1:0]   entry_bound,
    input  logic [BND_W-1:0]  len_bound,
    input  logic [RING_W-1:0] eff_ring,
    input  logic [RING_W-1:0] proc_ring,
    input  logic [SEG_W-1:0]  proc_seg,
    input  logic [SEG_W-1:0]  tgt_seg,
    input  logic [ADDR_W-1:0] comp_addr,
    input  logic [RING_W-1:0] alarm_ring,
    input  logic              abs_mode,
    output logic [MASK_W-1:0] viol_mask,
    output logic              fault,
    output logic [RING_W-1:0] ring_out
);
    logic [MASK_W-1:0] m_common, m_read, m_xfer, m_call;
    logic [RING_W-1:0] r_read, r_xfer, r_call;
    logic [MASK_W-1:0] sel_mask;
    logic [RING_W-1:0] sel_ring;
    logic              sel_fault;
    acc_class_e        cls;

    hold_state_e       state_q, state_d;
    logic [MASK_W-1:0] cap_mask;
    logic              cap_fault;
    logic [RING_W-1:0] cap_ring;

    assign cls = acc_class_e'(acc_class);

    rc_common_rules #(.RING_W(RING_W), .BND_W(BND_W)) u_common (
        .br_low    (br_low),
        .br_mid    (br_mid),
        .br_high   (br_high),
        .addr_blk  (comp_addr[ADDR_W-1:LEN_SHIFT]),
        .len_bound (len_bound),
        .mask      (m_common)
    );

    rc_read_rules #(.RING_W(RING_W), .SEG_W(SEG_W)) u_read (
        .br_mid    (br_mid),
        .rd_permit (rd_permit),
        .eff_ring  (eff_ring),
        .proc_ring (proc_ring),
        .proc_seg  (proc_seg),
        .tgt_seg   (tgt_seg),
        .mask      (m_read),
        .ring_adj  (r_read)
    );

    rc_xfer_rules #(.RING_W(RING_W)) u_xfer (
        .br_low     (br_low),
        .br_mid     (br_mid),
        .exec_ok    (exec_ok),
        .eff_ring   (eff_ring),
        .proc_ring  (proc_ring),
        .alarm_ring (alarm_ring),
        .mask       (m_xfer),
        .ring_adj   (r_xfer)
    );

    rc_call_rules #(.RING_W(RING_W), .SEG_W(SEG_W), .ADDR_W(ADDR_W), .EB_W(EB_W)) u_call (
        .br_low      (br_low),
        .br_mid      (br_mid),
        .br_high     (br_high),
        .exec_ok     (exec_ok),
        .gate_seg    (gate_seg),
        .entry_bound (entry_bound),
        .eff_ring    (eff_ring),
        .proc_ring   (proc_ring),
        .proc_seg    (proc_seg),
        .tgt_seg     (tgt_seg),
        .comp_addr   (comp_addr),
        .abs_mode    (abs_mode),
        .mask        (m_call),
        .ring_adj    (r_call)
    );

    // class selection of the rule set
    always_comb begin
        unique case (cls)
            ACC_XFER: begin
                sel_mask = m_common | m_xfer;
                sel_ring = r_xfer;
            end
            ACC_CALL: begin
                sel_mask = m_common | m_call;
                sel_ring = r_call;
            end
            ACC_READ, ACC_READ_ALT: begin
                sel_mask = m_common | m_read;
                sel_ring = r_read;
            end
            default: begin
                sel_mask = m_common | m_read;
                sel_ring = r_read;
            end
        endcase
        sel_fault = |sel_mask;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (chk_valid) state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_HOLD;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_mask  <= '0;
            cap_fault <= 1'b0;
            cap_ring  <= '0;
        end else if (chk_valid) begin
            cap_mask  <= sel_mask;
            cap_fault <= sel_fault;
            cap_ring  <= sel_ring;
        end
    end

    // outputs per state
    always_comb begin
        unique case (state_q)
            ST_HOLD: begin
                viol_mask = cap_mask;
                fault     = cap_fault;
                ring_out  = cap_ring;
            end
            default: begin
                viol_mask = '0;
                fault     = 1'b0;
                ring_out  = '0;
            end
        endcase
    end

    // R8
    fault_match_chk: assert property (@(posedge clk) disable iff (rst)
        fault == (viol_mask != '0));

    // R9
    hold_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> ($stable(viol_mask) && $stable(ring_out)));

    // R9
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY) |-> (viol_mask == '0 && ring_out == '0));

    // R1
    order_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && ((br_low > br_mid) || (br_mid > br_high))) |=> viol_mask[V_ORDER]);

    // R4
    call_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && cls == ACC_CALL) |=> (ring_out <= $past(br_mid)));

    // R5
    xfer_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && cls == ACC_XFER) |=> (ring_out == $past(eff_ring)));

    // R2
    read_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && (cls == ACC_READ || cls == ACC_READ_ALT) && !rd_permit)
            |=> (ring_out == $past(proc_ring)));

endmodule

// File: tb/ring_access_checker_test.sv
module ring_access_checker_test;

    typedef struct packed {
        logic [1:0]  cls;
        logic [2:0]  r1, r2, r3;
        logic        rp, ex, gt;
        logic [13:0] eb, lb;
        logic [2:0]  eff, prr;
        logic [14:0] psr, tsr;
        logic [17:0] ca;
        logic [2:0]  ralr;
        logic        ab;
        logic [15:0] mask;
        logic [2:0]  ring;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        // cls r1 r2 r3 rp ex gt eb   lb       eff prr psr tsr ca     ralr ab mask      ring req
        '{0, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 10, 18'h40, 0, 0, 16'h0000, 2, 2},  // R2 clean read
        '{0, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 4, 2, 10, 10, 18'h40, 0, 0, 16'h0008, 4, 2},  // R2 ring above mid
        '{0, 1, 3, 5, 0, 1, 0, 100, 14'h3FFF, 4, 1, 10, 11, 18'h40, 0, 0, 16'h0018, 1, 2},  // R2 no permit, other seg
        '{0, 1, 3, 5, 0, 1, 0, 100, 14'h3FFF, 2, 6, 10, 10, 18'h40, 0, 0, 16'h0000, 6, 2},  // R2 no permit, same seg
        '{0, 4, 3, 5, 1, 1, 0, 100, 14'h3FFF, 3, 2, 10, 10, 18'h40, 0, 0, 16'h0001, 3, 1},  // R1 bad order on read
        '{1, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 10, 18'h40, 0, 0, 16'h0000, 2, 5},  // R5 clean transfer
        '{1, 1, 3, 5, 1, 0, 0, 100, 14'h3FFF, 4, 2, 10, 10, 18'h40, 0, 0, 16'h1006, 4, 5},  // R5 three bits
        '{1, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 10, 18'h40, 2, 0, 16'h2000, 2, 6},  // R6 alarm equal
        '{1, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 10, 18'h40, 3, 0, 16'h0000, 2, 6},  // R6 alarm above
        '{2, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 11, 18'h40, 0, 0, 16'h0000, 2, 3},  // R3 clean call
        '{2, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 11, 18'd100, 0, 0, 16'h0080, 2, 3}, // R3 at entry bound
        '{2, 1, 3, 5, 1, 1, 1, 100, 14'h3FFF, 2, 2, 10, 11, 18'd100, 0, 0, 16'h0000, 2, 3}, // R3 gate skips
        '{2, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 10, 18'd100, 0, 0, 16'h0000, 2, 3}, // R3 same seg skips
        '{2, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 10, 18'd100, 0, 1, 16'h0080, 2, 3}, // R3 absolute no skip
        '{2, 1, 3, 5, 1, 0, 0, 100, 14'h3FFF, 6, 2, 10, 11, 18'h40, 0, 0, 16'h0504, 3, 4},  // R4 multi + clamp
        '{2, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 0, 0, 10, 11, 18'h40, 0, 0, 16'h0200, 0, 4},  // R4 below low
        '{2, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 4, 3, 10, 11, 18'h40, 0, 0, 16'h0000, 3, 4},  // R4 clamp only
        '{2, 1, 3, 5, 1, 1, 0, 100, 14'd5,   2, 2, 10, 11, 18'h60, 0, 0, 16'h8000, 2, 7},  // R7 length on call
        '{0, 1, 3, 5, 1, 1, 0, 100, 14'd5,   2, 2, 10, 10, 18'h5F, 0, 0, 16'h0000, 2, 7},  // R7 length equal
        '{3, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 4, 2, 10, 10, 18'h40, 0, 0, 16'h0008, 4, 10}, // R10 code 3 reads
        '{1, 1, 7, 7, 1, 1, 0, 100, 14'h3FFF, 7, 7, 10, 10, 18'h40, 0, 0, 16'h0000, 7, 6},  // R6 zero alarm
        '{1, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 0, 0, 10, 10, 18'h40, 0, 0, 16'h0002, 0, 5},  // R5 below low
        '{1, 1, 3, 5, 0, 1, 0, 100, 14'h3FFF, 2, 2, 10, 11, 18'h40, 0, 0, 16'h0000, 2, 10}, // R10 permit ignored
        '{2, 1, 5, 4, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 11, 18'h40, 0, 0, 16'h0001, 2, 1},  // R1 bad order on call
        '{0, 1, 3, 5, 1, 1, 0, 100, 14'h3FFF, 2, 2, 10, 10, 18'h40, 2, 0, 16'h0000, 2, 10}  // R10 alarm ignored
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        chk_valid;
    logic [1:0]  acc_class;
    logic [2:0]  br_low, br_mid, br_high;
    logic        rd_permit, exec_ok, gate_seg;
    logic [13:0] entry_bound, len_bound;
    logic [2:0]  eff_ring, proc_ring;
    logic [14:0] proc_seg, tgt_seg;
    logic [17:0] comp_addr;
    logic [2:0]  alarm_ring;
    logic        abs_mode;
    logic [15:0] viol_mask;
    logic        fault;
    logic [2:0]  ring_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ring_access_checker uut (
        .clk(clk), .rst(rst), .chk_valid(chk_valid), .acc_class(acc_class),
        .br_low(br_low), .br_mid(br_mid), .br_high(br_high),
        .rd_permit(rd_permit), .exec_ok(exec_ok), .gate_seg(gate_seg),
        .entry_bound(entry_bound), .len_bound(len_bound),
        .eff_ring(eff_ring), .proc_ring(proc_ring),
        .proc_seg(proc_seg), .tgt_seg(tgt_seg), .comp_addr(comp_addr),
        .alarm_ring(alarm_ring), .abs_mode(abs_mode),
        .viol_mask(viol_mask), .fault(fault), .ring_out(ring_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        acc_class   = v.cls;
        br_low      = v.r1;  br_mid = v.r2;  br_high = v.r3;
        rd_permit   = v.rp;  exec_ok = v.ex; gate_seg = v.gt;
        entry_bound = v.eb;  len_bound = v.lb;
        eff_ring    = v.eff; proc_ring = v.prr;
        proc_seg    = v.psr; tgt_seg = v.tsr;
        comp_addr   = v.ca;  alarm_ring = v.ralr; abs_mode = v.ab;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        chk_valid = 1'b0;
        apply(TBL[6]);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state: nothing captured yet
        check("R9", "reset mask", 32'(viol_mask), 32'h0);
        check("R9", "reset fault", 32'(fault), 32'h0);
        check("R9", "reset ring", 32'(ring_out), 32'h0);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d", TBL[k].req);
            apply(TBL[k]);
            chk_valid = 1'b1;
            @(negedge clk);
            chk_valid = 1'b0;
            check(tag, $sformatf("vec %0d mask", k), 32'(viol_mask), 32'(TBL[k].mask));
            check(tag, $sformatf("vec %0d ring", k), 32'(ring_out), 32'(TBL[k].ring));
            // R8 fault tracks a nonzero mask
            check("R8", $sformatf("vec %0d fault", k), 32'(fault), 32'(TBL[k].mask != 0));
        end

        // R9 hold: load a faulting call, then disturb inputs without strobe
        apply(TBL[14]);
        chk_valid = 1'b1;
        @(negedge clk);
        chk_valid = 1'b0;
        apply(TBL[0]);
        repeat (3) @(negedge clk);
        check("R9", "held mask", 32'(viol_mask), 32'h0504);
        check("R9", "held ring", 32'(ring_out), 32'h3);
        check("R8", "held fault", 32'(fault), 32'h1);

        // R9 reload replaces the held result
        chk_valid = 1'b1;
        @(negedge clk);
        chk_valid = 1'b0;
        check("R9", "reload mask", 32'(viol_mask), 32'h0);
        check("R8", "reload fault", 32'(fault), 32'h0);

        // R9 reset while holding clears outputs
        apply(TBL[6]);
        chk_valid = 1'b1;
        @(negedge clk);
        chk_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "post reset mask", 32'(viol_mask), 32'h0);
        check("R9", "post reset ring", 32'(ring_out), 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule